// File: doc/BRIEF.md
# Shift, Round and Saturate Output Stage

This block sits at the end of a multiply-accumulate datapath. It takes one wide signed accumulator word per lane and reduces it to a narrow output sample. Each lane is shifted right arithmetically by a configured amount of 0 to 61 bits. The bits that fall off are then used to round the result under one of eight selectable rules. Finally the result is clamped to the signed range of the output width.

A complex operand is carried as two lanes, real part in lane 0 and imaginary part in lane 1. Both lanes share one shift and one rounding rule but are computed independently.

The input and the output are each a valid/ready stream. The pipeline has two register stages. It accepts one word per cycle and returns each result two cycles after it was accepted, unless the output is held back. The shift and mode inputs are sampled together with each accepted word, so they may change between words.

Top module: `srs_out_stage`

## Requirements
- R1: After synchronous reset, out_valid is 0 and in_ready is 1.
- R2: Mode code 0 shifts right arithmetically and rounds toward negative infinity, which is floor.
- R3: Mode code 1 rounds toward positive infinity, which is ceiling: any nonzero discarded bit raises the result by one.
- R4: Modes 2 and 3 round to the nearest value. On an exact half, mode 2 goes toward positive infinity and mode 3 goes toward negative infinity.
- R5: Modes 4 and 5 round to the nearest value. On an exact half, mode 4 goes away from zero and mode 5 goes toward zero.
- R6: Modes 6 and 7 round to the nearest value. On an exact half, mode 6 picks the even result and mode 7 picks the odd result.
- R7: With a shift of 0, every mode passes the input unchanged to saturation.
- R8: A rounded result above the output range gives the largest representable value. A result below the range gives the most negative one. OUT_W is a parameter, 16 or 32.
- R9: Shift codes 62 and 63 behave exactly like a shift of 61.
- R10: Latency is 2 cycles. A word accepted on one clock edge appears on out_valid after the second following edge, and one word is accepted per cycle while out_ready is 1.
- R11: While out_valid is 1 and out_ready is 0, out_smp holds steady. When both stages are full, in_ready drops. No word is lost or duplicated under backpressure.
- R12: Lane L occupies bits [L*ACC_W +: ACC_W] of in_acc and [L*OUT_W +: OUT_W] of out_smp. Lanes are computed independently with the shared configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_shift | input | 6 | Right-shift amount; values above 61 are treated as 61 |
| cfg_mode | input | 3 | Rounding rule code 0..7 |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Stage can take a word this cycle |
| in_acc | input | LANES*ACC_W | Signed accumulator per lane |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_smp | output | LANES*OUT_W | Rounded, saturated sample per lane |

## Verification
The rounding rules are exercised on every value from -9 to 9 under shifts of 1, 2 and 3. This covers values just below, exactly at and just above each half point, for both signs and for odd and even floors, which is what separates the eight modes from one another.

Values at and just past the output limits separate correct clamping from wrap-around. Shift codes beyond the limit, applied to a value whose quotient is 2.5, separate clamping of the shift from a raw shift. Unequal lane values show any crossing of lanes. A long run of random words under random and forced backpressure shows any loss, duplication or change of a held result.

// File: rtl/srs_pkg.sv
package srs_pkg;

    localparam int unsigned SHIFT_W     = 6;
    localparam int unsigned SHIFT_LIMIT = 61;

    typedef enum logic [2:0] {
        RND_FLOOR      = 3'd0,
        RND_CEIL       = 3'd1,
        RND_HALF_UP    = 3'd2,
        RND_HALF_DOWN  = 3'd3,
        RND_HALF_AWAY  = 3'd4,
        RND_HALF_ZERO  = 3'd5,
        RND_HALF_EVEN  = 3'd6,
        RND_HALF_ODD   = 3'd7
    } rnd_mode_e;

    // Summary of the discarded bits, enough to decide the increment.
    typedef struct packed {
        logic above;    // discarded part greater than one half
        logic tie;      // discarded part exactly one half
        logic nonzero;  // any discarded bit set
        logic neg;      // operand negative
        logic lsb;      // lowest bit of the floored quotient
    } tail_t;

    function automatic logic round_up(rnd_mode_e mode, tail_t t);
        logic inc;
        case (mode)
            RND_FLOOR:     inc = 1'b0;
            RND_CEIL:      inc = t.nonzero;
            RND_HALF_UP:   inc = t.above | t.tie;
            RND_HALF_DOWN: inc = t.above;
            RND_HALF_AWAY: inc = t.above | (t.tie & ~t.neg);
            RND_HALF_ZERO: inc = t.above | (t.tie & t.neg);
            RND_HALF_EVEN: inc = t.above | (t.tie & t.lsb);
            RND_HALF_ODD:  inc = t.above | (t.tie & ~t.lsb);
            default:       inc = 1'b0;
        endcase
        return inc;
    endfunction

endpackage

// File: rtl/srs_tail_split.sv
module srs_tail_split
    import srs_pkg::*;
#(
    parameter int unsigned ACC_W = 80
) (
    input  logic signed [ACC_W-1:0]   acc_i,
    input  logic        [SHIFT_W-1:0] shift_i,
    output logic signed [ACC_W-1:0]   floor_o,
    output tail_t                     tail_o
);
    logic [ACC_W-1:0]   low_mask;
    logic [ACC_W-1:0]   frac;
    logic [ACC_W-1:0]   half;
    logic [SHIFT_W-1:0] shift_m1;
    logic               any_shift;

    always_comb begin
        any_shift = (shift_i != '0);
        shift_m1  = shift_i - SHIFT_W'(1);
        low_mask  = ~({ACC_W{1'b1}} << shift_i);
        frac      = acc_i & low_mask;
        half      = any_shift ? ({{(ACC_W-1){1'b0}}, 1'b1} << shift_m1) : '0;
        floor_o   = acc_i >>> shift_i;

        tail_o.above   = any_shift && (frac > half);
        tail_o.tie     = any_shift && (frac == half);
        tail_o.nonzero = (frac != '0);
        tail_o.neg     = acc_i[ACC_W-1];
        tail_o.lsb     = floor_o[0];
    end
endmodule

// File: rtl/srs_lane_finish.sv
module srs_lane_finish
    import srs_pkg::*;
#(
    parameter int unsigned ACC_W = 80,
    parameter int unsigned OUT_W = 16
) (
    input  logic signed [ACC_W-1:0] floor_i,
    input  tail_t                   tail_i,
    input  rnd_mode_e               mode_i,
    output logic [OUT_W-1:0]        smp_o
);
    localparam int unsigned PAD = ACC_W - OUT_W + 2;
    localparam logic signed [ACC_W:0] OUT_MAX = {{PAD{1'b0}}, {(OUT_W-1){1'b1}}};
    localparam logic signed [ACC_W:0] OUT_MIN = ~OUT_MAX;

    logic              inc;
    logic signed [ACC_W:0] sum;

    always_comb begin
        inc = round_up(mode_i, tail_i);
        sum = {floor_i[ACC_W-1], floor_i} + {{ACC_W{1'b0}}, inc};
        if (sum > OUT_MAX)
            smp_o = OUT_MAX[OUT_W-1:0];
        else if (sum < OUT_MIN)
            smp_o = OUT_MIN[OUT_W-1:0];
        else
            smp_o = sum[OUT_W-1:0];
    end
endmodule

// File: rtl/srs_pipe_ctrl.sv
module srs_pipe_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    input  logic out_ready,
    output logic adv_o,
    output logic s1_vld_o,
    output logic s2_vld_o
);
    always_comb adv_o = out_ready || !s2_vld_o;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_vld_o <= 1'b0;
            s2_vld_o <= 1'b0;
        end else if (adv_o) begin
            s1_vld_o <= in_valid;
            s2_vld_o <= s1_vld_o;
        end
    end
endmodule

// File: rtl/srs_out_stage.sv
module srs_out_stage
    import srs_pkg::*;
#(
    parameter int unsigned ACC_W = 80,
    parameter int unsigned OUT_W = 16,
    parameter int unsigned LANES = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [SHIFT_W-1:0]       cfg_shift,
    input  logic [2:0]               cfg_mode,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic [LANES*ACC_W-1:0]   in_acc,
    output logic                     out_valid,
    input  logic                     out_ready,
    output logic [LANES*OUT_W-1:0]   out_smp
);
    logic               adv;
    logic               s1_vld;
    logic               s2_vld;
    logic [SHIFT_W-1:0] shift_eff;
    rnd_mode_e          s1_mode;

    always_comb begin
        shift_eff = (cfg_shift > SHIFT_W'(SHIFT_LIMIT)) ? SHIFT_W'(SHIFT_LIMIT) : cfg_shift;
    end

    srs_pipe_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .out_ready (out_ready),
        .adv_o     (adv),
        .s1_vld_o  (s1_vld),
        .s2_vld_o  (s2_vld)
    );

    always_ff @(posedge clk) begin
        if (rst)
            s1_mode <= RND_FLOOR;
        else if (adv)
            s1_mode <= rnd_mode_e'(cfg_mode);
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic signed [ACC_W-1:0] c_floor;
        tail_t                   c_tail;
        logic signed [ACC_W-1:0] r_floor;
        tail_t                   r_tail;
        logic [OUT_W-1:0]        c_smp;
        logic [OUT_W-1:0]        r_smp;

        srs_tail_split #(.ACC_W(ACC_W)) u_split (
            .acc_i   (in_acc[l*ACC_W +: ACC_W]),
            .shift_i (shift_eff),
            .floor_o (c_floor),
            .tail_o  (c_tail)
        );

        always_ff @(posedge clk) begin
            if (rst) begin
                r_floor <= '0;
                r_tail  <= '0;
            end else if (adv) begin
                r_floor <= c_floor;
                r_tail  <= c_tail;
            end
        end

        srs_lane_finish #(.ACC_W(ACC_W), .OUT_W(OUT_W)) u_finish (
            .floor_i (r_floor),
            .tail_i  (r_tail),
            .mode_i  (s1_mode),
            .smp_o   (c_smp)
        );

        always_ff @(posedge clk) begin
            if (rst)
                r_smp <= '0;
            else if (adv)
                r_smp <= c_smp;
        end

        assign out_smp[l*OUT_W +: OUT_W] = r_smp;
    end

    assign in_ready  = adv;
    assign out_valid = s2_vld;

endmodule

// File: rtl/srs_out_stage_chk.sv
module srs_out_stage_chk #(
    parameter int unsigned OUT_BITS = 32
) (
    input logic                clk,
    input logic                rst,
    input logic                in_valid,
    input logic                in_ready,
    input logic                out_valid,
    input logic                out_ready,
    input logic [OUT_BITS-1:0] out_smp,
    input logic                s1_vld
);
    // R1: pipeline is empty on the first cycle out of reset
    assert_reset_empty_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && !s1_vld && in_ready));

    // R11: a refused result stays put
    assert_hold_on_stall_R11: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_smp)));

    // R10: an accepted word reaches the first stage on the next edge
    assert_accept_to_s1_R10: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> s1_vld);

    // R10: a first-stage word reaches the output on the following edge
    assert_s1_to_out_R10: assert property (@(posedge clk) disable iff (rst)
        (s1_vld && in_ready) |=> out_valid);

    // R10: no result appears without a first-stage word behind it
    assert_out_needs_source_R10: assert property (@(posedge clk) disable iff (rst)
        (!s1_vld && in_ready) |=> !out_valid);
endmodule

bind srs_out_stage srs_out_stage_chk #(.OUT_BITS(LANES*OUT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_smp   (out_smp),
    .s1_vld    (s1_vld)
);

// File: tb/srs_out_stage_tb.sv
module srs_out_stage_tb;
    localparam int ACC_W = 80;
    localparam int OUT_W = 16;
    localparam int LANES = 2;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic                   rst;
    logic [5:0]             cfg_shift;
    logic [2:0]             cfg_mode;
    logic                   in_valid;
    logic                   in_ready;
    logic [LANES*ACC_W-1:0] in_acc;
    logic                   out_valid;
    logic                   out_ready;
    logic [LANES*OUT_W-1:0] out_smp;

    srs_out_stage #(.ACC_W(ACC_W), .OUT_W(OUT_W), .LANES(LANES)) u_dut (
        .clk(clk), .rst(rst), .cfg_shift(cfg_shift), .cfg_mode(cfg_mode),
        .in_valid(in_valid), .in_ready(in_ready), .in_acc(in_acc),
        .out_valid(out_valid), .out_ready(out_ready), .out_smp(out_smp)
    );

    logic [LANES*OUT_W-1:0] exp_q[$];
    string                  tag_q[$];
    int  n_chk = 0;
    int  n_bad = 0;
    bit  bp_en = 0;
    bit  force_stall = 0;

    task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Model: floor by arithmetic shift, remainder compared against one half.
    function automatic logic [OUT_W-1:0] ref_lane(logic signed [ACC_W-1:0] x, int sh, int md);
        logic signed [ACC_W+3:0] xw, q, r, one, two_r, lim_hi, lim_lo;
        bit gt, tie, nz, up;
        int s;
        s = (sh > 61) ? 61 : sh;
        xw = x;
        up = 0;
        if (s == 0) begin
            q = xw;
        end else begin
            q = xw >>> s;
            r = xw - (q <<< s);
            one = '0;
            one[s] = 1'b1;
            two_r = r <<< 1;
            gt  = two_r > one;
            tie = two_r == one;
            nz  = r != 0;
            case (md)
                0: up = 0;
                1: up = nz;
                2: up = gt || tie;
                3: up = gt;
                4: up = gt || (tie && xw >= 0);
                5: up = gt || (tie && xw < 0);
                6: up = gt || (tie && q[0]);
                default: up = gt || (tie && !q[0]);
            endcase
        end
        if (up) q = q + 1;
        lim_hi = '0;
        lim_hi[OUT_W-1] = 1'b1;
        lim_hi = lim_hi - 1;
        lim_lo = -lim_hi - 1;
        if (q > lim_hi) q = lim_hi;
        else if (q < lim_lo) q = lim_lo;
        return q[OUT_W-1:0];
    endfunction

    task automatic send(logic signed [ACC_W-1:0] a0, logic signed [ACC_W-1:0] a1, string tag);
        exp_q.push_back({ref_lane(a1, cfg_shift, cfg_mode), ref_lane(a0, cfg_shift, cfg_mode)});
        tag_q.push_back(tag);
        @(negedge clk);
        in_valid = 1'b1;
        in_acc   = {a1, a0};
        forever begin
            #1;
            if (in_ready) begin
                @(posedge clk);
                break;
            end
            @(negedge clk);
        end
        in_valid <= 1'b0;
    endtask

    task automatic drain();
        wait (exp_q.size() == 0);
        repeat (2) @(negedge clk);
    endtask

    task automatic set_cfg(int sh, int md);
        drain();
        cfg_shift = 6'(sh);
        cfg_mode  = 3'(md);
    endtask

    always @(negedge clk) begin
        if (force_stall)   out_ready = 1'b0;
        else if (bp_en)    out_ready = ($urandom % 3) != 0;
        else               out_ready = 1'b1;
    end

    // Scoreboard monitor: a transfer is counted at the edge following this sample.
    always @(negedge clk) begin
        #1;
        if (!rst && out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R11 extra output", 64'(out_smp), 64'(0));
            end else begin
                logic [LANES*OUT_W-1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(out_smp == e, t, 64'(out_smp), 64'(e));
            end
        end
    end

    task automatic summary();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R10 watchdog actual=hung expected=finished");
        summary();
    end

    initial begin
        string mtag [8] = '{"R2", "R3", "R4", "R4", "R5", "R5", "R6", "R6"};
        rst = 1'b1; in_valid = 1'b0; in_acc = '0; cfg_shift = '0; cfg_mode = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk); #1;
        check(out_valid == 1'b0, "R1 out_valid", 64'(out_valid), 64'(0));
        check(in_ready == 1'b1, "R1 in_ready", 64'(in_ready), 64'(1));

        // R10: two-cycle latency
        set_cfg(0, 0);
        send(80'sd1234, -80'sd77, "R7");
        @(negedge clk); #1;
        check(out_valid == 1'b0, "R10 early", 64'(out_valid), 64'(0));
        @(negedge clk); #1;
        check(out_valid == 1'b1, "R10 on time", 64'(out_valid), 64'(1));

        // R2..R6: every mode around every half point
        for (int sh = 1; sh <= 3; sh++) begin
            for (int md = 0; md < 8; md++) begin
                set_cfg(sh, md);
                for (int v = -9; v <= 9; v++)
                    send(ACC_W'(v), ACC_W'(-v - 1), mtag[md]);
            end
        end

        // R7: shift of zero passes through
        for (int md = 0; md < 8; md++) begin
            set_cfg(0, md);
            send(80'sd32767, -80'sd32768, "R7");
            send(-80'sd5, 80'sd12345, "R7");
        end

        // R8: clamping at both ends
        for (int md = 0; md < 8; md += 2) begin
            set_cfg(4, md);
            send(80'sd1 <<< 40, -(80'sd1 <<< 40), "R8");
            send(80'sd32767 <<< 4, -(80'sd32768 <<< 4), "R8");
            send((80'sd32767 <<< 4) + 80'sd8, -(80'sd32768 <<< 4) - 80'sd1, "R8");
        end

        // R9: shift codes above the limit act as 61
        for (int sh = 61; sh <= 63; sh++) begin
            for (int md = 6; md < 8; md++) begin
                set_cfg(sh, md);
                send(80'sd5 <<< 60, -(80'sd5 <<< 60), "R9");
                send(80'sd7 <<< 60, 80'sd3 <<< 60, "R9");
            end
        end

        // R12: lanes independent under a shared rule
        set_cfg(2, 4);
        send(80'sd6, -80'sd6, "R12");
        send(-80'sd10, 80'sd14, "R12");

        // R11: full pipeline drops in_ready and holds its output
        drain();
        force_stall = 1'b1;
        @(negedge clk);
        send(80'sd100, 80'sd200, "R11");
        send(80'sd300, 80'sd400, "R11");
        @(negedge clk); #1;
        check(in_ready == 1'b0, "R11 in_ready full", 64'(in_ready), 64'(0));
        check(out_valid == 1'b1, "R11 out_valid held", 64'(out_valid), 64'(1));
        repeat (3) @(negedge clk);
        #1;
        check(out_smp == exp_q[0], "R11 held data", 64'(out_smp), 64'(exp_q[0]));
        force_stall = 1'b0;

        // R11: random traffic under random backpressure
        for (int b = 0; b < 8; b++) begin
            set_cfg(20, b);
            bp_en = 1'b1;
            for (int k = 0; k < 40; k++)
                send(ACC_W'($signed(32'($urandom))), ACC_W'($signed(32'($urandom))), "R11");
            bp_en = 1'b0;
        end

        drain();
        summary();
    end
endmodule